// File: doc/BRIEF.md
# Two-Channel DMA Control and Status Register File

This block is the software-visible register file of a two-channel DMA engine. Channel 0 moves data from memory to a stream and channel 1 moves data from a stream to memory. Software reaches the block over a simple 32-bit register bus with separate read and write strobes. Each channel has a 48-byte window. Inside that window sit a control word, a status word, a current-descriptor pointer and a tail-descriptor pointer. The remaining word slots act as plain storage.

The block drives run and soft-reset levels to each channel engine, plus one start pulse to the transmit engine. It raises one interrupt line per channel. The descriptor engines and the interrupt-coalescing logic are outside the block. They report events into the status word through set pulses. They also supply live completion and delay-timer counts, which appear in the upper half of the status readback.

Top module: `dma_csr`

## Requirements
- R1: After hardware reset, the control word of each channel reads 0x00010002: the completion-threshold field [23:16] holds 1 and bit 1 is set. The status word reads with halted (bit 0) set and all other stored bits clear. The pointer and spare words read 0, and all outputs are low.
- R2: The word index is addr[6:2]. The channel is bit 0 of (word index / 12), and the offset within the window is (word index mod 12). Offset 0 is control, 1 is status, 2 is the current descriptor and 4 is the tail descriptor. The other offsets are independent read/write storage in each channel. The current and tail words appear on `cur_desc_o` and `tail_desc_o`.
- R3: Control bit 1 (tail-pointer mode) always reads back as 1, whatever was written.
- R4: Writing control with bit 2 (soft reset) set has two effects: control becomes 0x00010006 and status becomes halted only. Bit 2 then stays set through later control writes, each of which restores those values again. The next control read returns the word with bit 2 set, and that read clears bit 2.
- R5: A control write with bit 0 (run) set, while soft reset is not pending, clears status bits 0 (halted) and 1 (idle). While soft reset is pending, run is not honoured.
- R6: Status bits [14:12] are interrupt flags. A status write clears each flag whose bit is written as 1 and leaves the others. Status bits 15 and [11:0] take the written value.
- R7: A pulse on a channel's flag-set input sets the matching status flags. The idle-set input sets bit 1 and the halt-set input sets bit 0. When an event coincides with a write that would clear the same bit, the event wins.
- R8: `irq_o[c]` is high exactly when some status flag [14:12] of channel c is set and control bit at the same position is also set.
- R9: A status read returns the delay count in [31:24], the completion count in [23:16] and the stored status in [15:0].
- R10: A tail-descriptor write clears the channel's idle bit. A write to channel 0's tail raises `tx_start_o` for exactly the following cycle. Channel 1 tail writes never pulse it.
- R11: `run_o[c]` follows control bit 0 and `soft_rst_o[c]` follows control bit 2 of channel c.
- R12: `rdata` is valid in the cycle after the one in which `rd_en` is high, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 7 | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| flag_set_i | input | 6 | Per-channel interrupt-flag set pulses, 3 bits per channel |
| idle_set_i | input | 2 | Per-channel idle-set pulse |
| halt_set_i | input | 2 | Per-channel halt-set pulse |
| cmpl_cnt_i | input | 16 | Per-channel live completion count, 8 bits each |
| dly_cnt_i | input | 16 | Per-channel live delay-timer count, 8 bits each |
| run_o | output | 2 | Per-channel run level |
| soft_rst_o | output | 2 | Per-channel pending soft reset |
| tx_start_o | output | 1 | One-cycle start to the transmit descriptor engine |
| irq_o | output | 2 | Per-channel interrupt |
| cur_desc_o | output | 64 | Per-channel current-descriptor pointer, 32 bits each |
| tail_desc_o | output | 64 | Per-channel tail-descriptor pointer, 32 bits each |

## Verification
Two paths can act on the same status bit in one cycle: a software write-one-to-clear to an interrupt flag, and an event pulse that sets that flag. The bench first sets a flag and then issues the clearing write with the set pulse held in the same clock. It judges the result by reading status back and by watching the interrupt line; both must show the flag still set. A second clearing write without the event must then drop the flag and the interrupt.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int DATA_W    = 32;
  localparam int STAT_W    = 16;
  localparam int CNT_W     = 8;
  localparam int FLAG_W    = 3;
  localparam int FLAG_LO   = 12;
  localparam int FLAG_HI   = FLAG_LO + FLAG_W - 1;
  localparam int THRESH_LO = 16;

  localparam int RUN_BIT   = 0;
  localparam int MODE_BIT  = 1;
  localparam int SRST_BIT  = 2;
  localparam int HALT_BIT  = 0;
  localparam int IDLE_BIT  = 1;

  localparam int WIN_WORDS = 12;
  localparam int OFF_W     = $clog2(WIN_WORDS);
  localparam int PLAIN_LO  = 2;

  localparam logic [OFF_W-1:0] OFF_CTRL = OFF_W'(0);
  localparam logic [OFF_W-1:0] OFF_STAT = OFF_W'(1);
  localparam logic [OFF_W-1:0] OFF_CUR  = OFF_W'(2);
  localparam logic [OFF_W-1:0] OFF_TAIL = OFF_W'(4);

  localparam logic [DATA_W-1:0] MODE_MASK = DATA_W'(1) << MODE_BIT;
  localparam logic [DATA_W-1:0] SRST_MASK = DATA_W'(1) << SRST_BIT;
  localparam logic [DATA_W-1:0] CTRL_RST  = (DATA_W'(1) << THRESH_LO) | MODE_MASK;
  localparam logic [STAT_W-1:0] STAT_RST  = STAT_W'(1) << HALT_BIT;
endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int NCH    = 2,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [ADDR_W-3:0] word_i,
  output logic [CH_W-1:0]   ch_o,
  output logic [OFF_W-1:0]  off_o
);
  logic [31:0] word_ext;

  assign word_ext = 32'(word_i);
  assign ch_o     = CH_W'((word_ext / WIN_WORDS) % NCH);
  assign off_o    = OFF_W'(word_ext % WIN_WORDS);
endmodule

// File: rtl/dma_csr_chan.sv
module dma_csr_chan
  import dma_csr_pkg::*;
#(
  parameter bit IS_TX = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [FLAG_W-1:0] flag_set_i,
  input  logic              idle_set_i,
  input  logic              halt_set_i,
  input  logic [CNT_W-1:0]  cmpl_cnt_i,
  input  logic [CNT_W-1:0]  dly_cnt_i,
  output logic [DATA_W-1:0] rd_word_o,
  output logic              run_o,
  output logic              soft_rst_o,
  output logic              irq_o,
  output logic              start_o,
  output logic [DATA_W-1:0] cur_o,
  output logic [DATA_W-1:0] tail_o
);
  logic [DATA_W-1:0] ctrl_q, ctrl_d, cw;
  logic              ctrl_en;
  logic [STAT_W-1:0] stat_q, stat_d;
  logic [DATA_W-1:0] plain_q [PLAIN_LO:WIN_WORDS-1];
  logic wr_ctrl, rd_ctrl, wr_stat, wr_tail;

  assign wr_ctrl = wr_i && (off_i == OFF_CTRL);
  assign rd_ctrl = rd_i && (off_i == OFF_CTRL);
  assign wr_stat = wr_i && (off_i == OFF_STAT);
  assign wr_tail = wr_i && (off_i == OFF_TAIL);
  assign ctrl_en = wr_ctrl || rd_ctrl;

  // next state of control and status
  always_comb begin
    ctrl_d = ctrl_q;
    stat_d = stat_q;
    cw     = wdata_i | MODE_MASK | (ctrl_q & SRST_MASK);
    if (wr_ctrl) begin
      if (cw[SRST_BIT]) begin
        ctrl_d = CTRL_RST | SRST_MASK;
        stat_d = STAT_RST;
      end else begin
        ctrl_d = cw;
        if (cw[RUN_BIT]) begin
          stat_d[HALT_BIT] = 1'b0;
          stat_d[IDLE_BIT] = 1'b0;
        end
      end
    end else if (rd_ctrl) begin
      ctrl_d[SRST_BIT] = 1'b0;
    end
    if (wr_stat) begin
      stat_d                  = wdata_i[STAT_W-1:0];
      stat_d[FLAG_HI:FLAG_LO] = stat_q[FLAG_HI:FLAG_LO] & ~wdata_i[FLAG_HI:FLAG_LO];
    end
    if (wr_tail) stat_d[IDLE_BIT] = 1'b0;
    // engine events take priority over software clears
    stat_d[FLAG_HI:FLAG_LO] = stat_d[FLAG_HI:FLAG_LO] | flag_set_i;
    if (idle_set_i) stat_d[IDLE_BIT] = 1'b1;
    if (halt_set_i) stat_d[HALT_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RST;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= STAT_RST;
    else        stat_q <= stat_d;
  end

  for (genvar k = PLAIN_LO; k < WIN_WORDS; k++) begin : g_word
    logic word_we;
    assign word_we = wr_i && (off_i == OFF_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       plain_q[k] <= '0;
      else if (word_we) plain_q[k] <= wdata_i;
    end
  end

  always_comb begin
    rd_word_o = '0;
    if (off_i == OFF_CTRL)      rd_word_o = ctrl_q;
    else if (off_i == OFF_STAT) rd_word_o = {dly_cnt_i, cmpl_cnt_i, stat_q};
    else begin
      for (int k = PLAIN_LO; k < WIN_WORDS; k++) begin
        if (off_i == OFF_W'(k)) rd_word_o = plain_q[k];
      end
    end
  end

  if (IS_TX) begin : g_start
    logic start_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) start_q <= 1'b0;
      else        start_q <= wr_tail;
    end
    assign start_o = start_q;
  end else begin : g_nostart
    assign start_o = 1'b0;
  end

  assign run_o      = ctrl_q[RUN_BIT];
  assign soft_rst_o = ctrl_q[SRST_BIT];
  assign irq_o      = |(stat_q[FLAG_HI:FLAG_LO] & ctrl_q[FLAG_HI:FLAG_LO]);
  assign cur_o      = plain_q[OFF_CUR];
  assign tail_o     = plain_q[OFF_TAIL];
endmodule

// File: rtl/dma_csr.sv
module dma_csr
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int NCH    = 2,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  input  logic [NCH*FLAG_W-1:0]   flag_set_i,
  input  logic [NCH-1:0]          idle_set_i,
  input  logic [NCH-1:0]          halt_set_i,
  input  logic [NCH*CNT_W-1:0]    cmpl_cnt_i,
  input  logic [NCH*CNT_W-1:0]    dly_cnt_i,
  output logic [NCH-1:0]          run_o,
  output logic [NCH-1:0]          soft_rst_o,
  output logic                    tx_start_o,
  output logic [NCH-1:0]          irq_o,
  output logic [NCH*DATA_W-1:0]   cur_desc_o,
  output logic [NCH*DATA_W-1:0]   tail_desc_o
);
  logic [CH_W-1:0]   sel_ch;
  logic [OFF_W-1:0]  sel_off;
  logic [DATA_W-1:0] ch_word [NCH];
  logic [NCH-1:0]    ch_start;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              unused_lsb;

  assign unused_lsb = ^addr[1:0];

  dma_csr_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dec (
    .word_i (addr[ADDR_W-1:2]),
    .ch_o   (sel_ch),
    .off_o  (sel_off)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = (sel_ch == CH_W'(c));
    dma_csr_chan #(.IS_TX(c == 0)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (wr_en && hit),
      .rd_i       (rd_en && hit),
      .off_i      (sel_off),
      .wdata_i    (wdata),
      .flag_set_i (flag_set_i[c*FLAG_W +: FLAG_W]),
      .idle_set_i (idle_set_i[c]),
      .halt_set_i (halt_set_i[c]),
      .cmpl_cnt_i (cmpl_cnt_i[c*CNT_W +: CNT_W]),
      .dly_cnt_i  (dly_cnt_i[c*CNT_W +: CNT_W]),
      .rd_word_o  (ch_word[c]),
      .run_o      (run_o[c]),
      .soft_rst_o (soft_rst_o[c]),
      .irq_o      (irq_o[c]),
      .start_o    (ch_start[c]),
      .cur_o      (cur_desc_o[c*DATA_W +: DATA_W]),
      .tail_o     (tail_desc_o[c*DATA_W +: DATA_W])
    );
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = ch_word[sel_ch];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata      = rdata_q;
  assign tx_start_o = ch_start[0];
endmodule

// File: rtl/dma_csr_chk.sv
module dma_csr_chk #(
  parameter int ADDR_W = 7,
  parameter int NCH    = 2,
  parameter int WIN    = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-3:0] word,
  input logic              wd_srst,
  input logic [2:0]        wd_flags,
  input logic              rd_mode_bit,
  input logic [2:0]        flag_set0,
  input logic              soft_rst0,
  input logic              tx_start,
  input logic              irq0
);
  int unsigned slot;
  assign slot = 32'(word) % (WIN * NCH);

  AST_TX_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(wr_en && slot == 4)); // R10
  AST_MODE_READS_ONE_CH0: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && slot == 0) |=> rd_mode_bit); // R3
  AST_MODE_READS_ONE_CH1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && slot == WIN) |=> rd_mode_bit); // R3
  AST_SRST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && slot == 0 && wd_srst) |=> soft_rst0); // R4
  AST_SRST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst0 && !(rd_en && slot == 0)) |=> soft_rst0); // R4
  AST_W1C_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && slot == 1 && wd_flags == 3'b111 && flag_set0 == 3'b000) |=> !irq0); // R6
endmodule

bind dma_csr dma_csr_chk #(.ADDR_W(ADDR_W), .NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .word        (addr[ADDR_W-1:2]),
  .wd_srst     (wdata[2]),
  .wd_flags    (wdata[14:12]),
  .rd_mode_bit (rdata[1]),
  .flag_set0   (flag_set_i[2:0]),
  .soft_rst0   (soft_rst_o[0]),
  .tx_start    (tx_start_o),
  .irq0        (irq_o[0])
);

// File: tb/dma_csr_tb_top.sv
`timescale 1ns/1ps
module dma_csr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  flag_set_i = '0;
  logic [1:0]  idle_set_i = '0, halt_set_i = '0;
  logic [15:0] cmpl_cnt_i = 16'h0005;
  logic [15:0] dly_cnt_i  = 16'h000A;
  logic [1:0]  run_o, soft_rst_o, irq_o;
  logic        tx_start_o;
  logic [63:0] cur_desc_o, tail_desc_o;

  int n_run = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_q = 1'b0;

  always #10 clk = ~clk;

  dma_csr dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .flag_set_i(flag_set_i),
    .idle_set_i(idle_set_i), .halt_set_i(halt_set_i),
    .cmpl_cnt_i(cmpl_cnt_i), .dly_cnt_i(dly_cnt_i), .run_o(run_o),
    .soft_rst_o(soft_rst_o), .tx_start_o(tx_start_o), .irq_o(irq_o),
    .cur_desc_o(cur_desc_o), .tail_desc_o(tail_desc_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per completed read
  always @(posedge clk) rd_q <= rd_en;
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) chk("R12 unexpected read data", rdata, 32'hx);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic rd(logic [6:0] a, logic [31:0] e, string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr_ev(logic [6:0] a, logic [31:0] d, logic [5:0] fs);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; flag_set_i = fs;
    @(negedge clk);
    wr_en = 1'b0; flag_set_i = '0;
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    wr_ev(a, d, 6'b0);
  endtask

  task automatic ev(logic [5:0] fs, logic [1:0] idl, logic [1:0] hlt);
    @(negedge clk);
    flag_set_i = fs; idle_set_i = idl; halt_set_i = hlt;
    @(negedge clk);
    flag_set_i = '0; idle_set_i = '0; halt_set_i = '0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq low", {30'b0, irq_o}, 32'h0);
    chk("R1 start low", {31'b0, tx_start_o}, 32'h0);
    rd(7'h00, 32'h0001_0002, "R1 ch0 ctrl reset");
    rd(7'h04, 32'h0A05_0001, "R1 ch0 status reset");
    rd(7'h34, 32'h0000_0001, "R1 ch1 status reset");
    rd(7'h10, 32'h0, "R1 ch0 tail reset");
    // R3 / R5 / R11 run with all enables
    wr(7'h00, 32'h0000_7001);
    chk("R11 run_o ch0", {30'b0, run_o}, 32'h1);
    rd(7'h00, 32'h0000_7003, "R3 mode bit forced");
    rd(7'h04, 32'h0A05_0000, "R5 run clears halted; R9 counters");
    // R7 / R8 flag set and interrupt
    ev(6'b000_001, 2'b00, 2'b00);
    chk("R8 irq on flag12", {30'b0, irq_o}, 32'h1);
    rd(7'h04, 32'h0A05_1000, "R7 flag12 set");
    wr(7'h04, 32'h0000_1000);
    chk("R6 irq drops after W1C", {30'b0, irq_o}, 32'h0);
    rd(7'h04, 32'h0A05_0000, "R6 flag12 cleared");
    // R7 set beats clear in same cycle
    ev(6'b000_010, 2'b00, 2'b00);
    wr_ev(7'h04, 32'h0000_2000, 6'b000_010);
    rd(7'h04, 32'h0A05_2000, "R7 set wins over W1C");
    chk("R7 irq held", {30'b0, irq_o}, 32'h1);
    wr(7'h04, 32'h0000_2000);
    rd(7'h04, 32'h0A05_0000, "R6 flag13 cleared");
    // R8 enable mask
    wr(7'h00, 32'h0000_1001);
    ev(6'b000_100, 2'b00, 2'b00);
    chk("R8 masked flag no irq", {30'b0, irq_o}, 32'h0);
    rd(7'h04, 32'h0A05_4000, "R8 flag14 stored");
    wr(7'h04, 32'h0000_4000);
    // R10 transmit start pulse
    wr(7'h10, 32'h0000_0040);
    chk("R10 start pulse", {31'b0, tx_start_o}, 32'h1);
    @(negedge clk);
    chk("R10 start single cycle", {31'b0, tx_start_o}, 32'h0);
    chk("R2 tail out ch0", tail_desc_o[31:0], 32'h40);
    // R10 ch1 idle handling, no pulse
    ev(6'b0, 2'b10, 2'b00);
    rd(7'h34, 32'h0000_0003, "R7 idle set ch1");
    wr(7'h40, 32'h0000_0080);
    chk("R10 no start for ch1", {31'b0, tx_start_o}, 32'h0);
    rd(7'h34, 32'h0000_0001, "R10 tail clears idle");
    // R2 plain storage, channel separation
    wr(7'h0C, 32'hDEAD_BEEF);
    wr(7'h3C, 32'h1234_5678);
    wr(7'h08, 32'h0000_1000);
    rd(7'h0C, 32'hDEAD_BEEF, "R2 spare ch0");
    rd(7'h3C, 32'h1234_5678, "R2 spare ch1");
    chk("R2 cur out ch0", cur_desc_o[31:0], 32'h1000);
    // R4 soft reset on ch1
    wr(7'h30, 32'h0000_0004);
    chk("R11 soft_rst_o ch1", {30'b0, soft_rst_o}, 32'h2);
    wr(7'h30, 32'h0000_0001);
    chk("R5 run ignored in reset", {30'b0, run_o}, 32'h1);
    rd(7'h30, 32'h0001_0006, "R4 sticky reset readback");
    chk("R4 read clears reset", {30'b0, soft_rst_o}, 32'h0);
    rd(7'h30, 32'h0001_0002, "R4 ctrl after clear");
    wr(7'h30, 32'h0000_0001);
    chk("R11 run_o ch1", {30'b0, run_o}, 32'h3);
    rd(7'h34, 32'h0000_0000, "R5 ch1 running");
    // R7 halt event
    ev(6'b0, 2'b00, 2'b01);
    rd(7'h04, 32'h0A05_0001, "R7 halt set ch0");
    repeat (2) @(negedge clk);
    chk("R12 all reads scored", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule